// File: doc/BRIEF.md
# Load Data Extend and Unpack Unit

This block sits after the data-return path of a load pipe and turns raw read data into the value written to the register file. Each accepted request carries an operation code, a signedness bit, up to 64 bits of read data and the current contents of the 64-bit destination pair. The pair is needed only by the shift-in forms. From these the block forms either a 32-bit result, placed in the low half with the upper half cleared, or a full 64-bit result. A flag marks which of the two it is.

The operations are grouped by kind. Byte, halfword and word loads go through an extension path. A doubleword load is passed through whole. Unpack loads widen two or four bytes into 16-bit lanes. Shift-in loads slide the old pair towards the least significant end by one item and insert the new byte or halfword at the top. Lane 0 is always the least significant lane.

A small state machine tracks the registered output. It has three states. ST_EMPTY means no result has been captured since reset. ST_FRESH means a result was captured at the last edge, and the strobe is high. ST_HELD means the last result is still being shown without the strobe. From any state, a valid input moves the machine to ST_FRESH. Without a valid input, ST_FRESH moves to ST_HELD, and ST_EMPTY and ST_HELD stay where they are.

Top module: `ldx_unit`

## Requirements
- R1: While reset is low, out_valid, out_wide and out_result are all 0.
- R2: Op code 0 (byte) returns rd_data[7:0] in out_result[31:0]. The value is sign-extended when in_sign is 1 and zero-extended when it is 0. out_result[63:32] is 0 and out_wide is 0.
- R3: Op code 1 (halfword) returns rd_data[15:0] in out_result[31:0], extended in the same way as R2. out_result[63:32] is 0 and out_wide is 0.
- R4: Op code 2 (word) returns rd_data[31:0] in the low half. out_result[63:32] is 0 and out_wide is 0.
- R5: Op code 3 (doubleword) returns all 64 bits of rd_data with out_wide set to 1.
- R6: Op code 4 (two-byte unpack) puts byte i of rd_data into 16-bit lane i of out_result[31:0], for i = 0 and 1. Each byte is extended per in_sign. out_result[63:32] is 0 and out_wide is 0.
- R7: Op code 5 (four-byte unpack) puts byte i of rd_data into 16-bit lane i of the 64-bit result, for i = 0 to 3. Each byte is extended per in_sign, and out_wide is 1.
- R8: Op code 6 (byte shift-in) yields (pair_in >> 8) | (rd_data[7:0] << 56) with out_wide set to 1. in_sign has no effect.
- R9: Op code 7 (halfword shift-in) yields (pair_in >> 16) | (rd_data[15:0] << 48) with out_wide set to 1. in_sign has no effect.
- R10: out_valid is 1 in exactly the cycle after each cycle in which in_valid was 1 at the clock edge, and 0 in every other cycle. Back-to-back requests give back-to-back results.
- R11: Without in_valid, changes on in_op, in_sign, rd_data and pair_in have no effect. out_result and out_wide keep the last captured value.
- R12: Bits of rd_data above the item size of the operation have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code (0 byte, 1 half, 2 word, 3 doubleword, 4 unpack-2, 5 unpack-4, 6 byte shift-in, 7 half shift-in) |
| in_sign | input | 1 | 1 = sign-extend, 0 = zero-extend (byte, half, unpack) |
| rd_data | input | 64 | Raw read data, lowest address in bits 7:0 |
| pair_in | input | 64 | Current destination pair value for the shift-in forms |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_result | output | 64 | Formatted result, held between requests |
| out_wide | output | 1 | 1 when the result fills the whole 64-bit pair |

## Verification
Two things can meet in the same cycle. One is presenting a result with the strobe high. The other is capturing the next request, which moves the state machine from ST_FRESH back into ST_FRESH rather than into ST_HELD. This is provoked with a chain of back-to-back shift-in loads. Each load feeds the previous result, as the bench predicts it, back in as pair_in. The chain is judged right only if the strobe stays high through every cycle of the chain and each result holds all the earlier inserted items, shifted the right distance. A drop of the strobe in the last cycle confirms the return to ST_HELD.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    // Operation codes carried on in_op
    typedef enum logic [2:0] {
        OP_BYTE  = 3'd0,
        OP_HALF  = 3'd1,
        OP_WORD  = 3'd2,
        OP_PAIR  = 3'd3,
        OP_UNPK2 = 3'd4,
        OP_UNPK4 = 3'd5,
        OP_SHB   = 3'd6,
        OP_SHH   = 3'd7
    } ldx_op_e;

    // Item size seen by the scalar extension path
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } ldx_size_e;

    // Output register state
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FRESH = 2'd1,
        ST_HELD  = 2'd2
    } ldx_state_e;

endpackage

// File: rtl/ldx_extend.sv
module ldx_extend
    import ldx_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [WORD_W-1:0] raw,
    input  ldx_size_e         size,
    input  logic              sign,
    output logic [WORD_W-1:0] ext
);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic fill_b;
    logic fill_h;

    // Fill bit for the upper part: the item's top bit when signed, else 0
    assign fill_b = sign & raw[BYTE_W-1];
    assign fill_h = sign & raw[HALF_W-1];

    always_comb begin
        unique case (size)
            SZ_BYTE: ext = {{(WORD_W-BYTE_W){fill_b}}, raw[BYTE_W-1:0]};
            SZ_HALF: ext = {{(WORD_W-HALF_W){fill_h}}, raw[HALF_W-1:0]};
            SZ_WORD: ext = raw;
            default: ext = raw;
        endcase
    end

endmodule

// File: rtl/ldx_unpack.sv
module ldx_unpack #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [LANES*BYTE_W-1:0]   raw,
    input  logic                      sign,
    output logic [LANES*2*BYTE_W-1:0] lanes
);
    localparam int unsigned LANE_W = 2 * BYTE_W;

    // Byte g goes to lane g, lane 0 at the least significant end
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic fill;
        assign fill = sign & raw[g*BYTE_W + BYTE_W - 1];
        assign lanes[g*LANE_W +: LANE_W] = {{BYTE_W{fill}}, raw[g*BYTE_W +: BYTE_W]};
    end

endmodule

// File: rtl/ldx_fifo_shift.sv
module ldx_fifo_shift #(
    parameter int unsigned PAIR_W = 64,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [PAIR_W-1:BYTE_W] old_hi,
    input  logic [2*BYTE_W-1:0]    item,
    input  logic                   half_mode,
    output logic [PAIR_W-1:0]      shifted
);
    localparam int unsigned HALF_W = 2 * BYTE_W;

    logic [PAIR_W-1:0] by_byte;
    logic [PAIR_W-1:0] by_half;

    // The old pair drops its lowest item, and the new item enters at the top
    assign by_byte = {item[BYTE_W-1:0], old_hi[PAIR_W-1:BYTE_W]};
    assign by_half = {item[HALF_W-1:0], old_hi[PAIR_W-1:HALF_W]};

    assign shifted = half_mode ? by_half : by_byte;

endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
#(
    parameter int unsigned PAIR_W = 64,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_sign,
    input  logic [PAIR_W-1:0] rd_data,
    input  logic [PAIR_W-1:0] pair_in,
    output logic              out_valid,
    output logic [PAIR_W-1:0] out_result,
    output logic              out_wide
);
    localparam int unsigned WORD_W   = PAIR_W / 2;
    localparam int unsigned HALF_W   = 2 * BYTE_W;
    localparam int unsigned LANES_LO = WORD_W / HALF_W;
    localparam int unsigned LANES_HI = WORD_W / BYTE_W;

    ldx_op_e           op;
    ldx_size_e         size;
    ldx_state_e        state_q;
    ldx_state_e        state_d;
    logic [WORD_W-1:0] ext_w;
    logic [WORD_W-1:0] unpk_lo;
    logic [PAIR_W-1:0] unpk_hi;
    logic [PAIR_W-1:0] shifted;
    logic [PAIR_W-1:0] next_result;
    logic              next_wide;

    assign op = ldx_op_e'(in_op);

    // Item size for the scalar extension path
    always_comb begin
        unique case (op)
            OP_BYTE: size = SZ_BYTE;
            OP_HALF: size = SZ_HALF;
            default: size = SZ_WORD;
        endcase
    end

    ldx_extend #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_extend (
        .raw  (rd_data[WORD_W-1:0]),
        .size (size),
        .sign (in_sign),
        .ext  (ext_w)
    );

    ldx_unpack #(.LANES(LANES_LO), .BYTE_W(BYTE_W)) u_unpack_lo (
        .raw   (rd_data[LANES_LO*BYTE_W-1:0]),
        .sign  (in_sign),
        .lanes (unpk_lo)
    );

    ldx_unpack #(.LANES(LANES_HI), .BYTE_W(BYTE_W)) u_unpack_hi (
        .raw   (rd_data[LANES_HI*BYTE_W-1:0]),
        .sign  (in_sign),
        .lanes (unpk_hi)
    );

    ldx_fifo_shift #(.PAIR_W(PAIR_W), .BYTE_W(BYTE_W)) u_shift (
        .old_hi    (pair_in[PAIR_W-1:BYTE_W]),
        .item      (rd_data[HALF_W-1:0]),
        .half_mode (op == OP_SHH),
        .shifted   (shifted)
    );

    // Result selection by operation
    always_comb begin
        unique case (op)
            OP_BYTE, OP_HALF, OP_WORD: begin
                next_result = {{WORD_W{1'b0}}, ext_w};
                next_wide   = 1'b0;
            end
            OP_PAIR: begin
                next_result = rd_data;
                next_wide   = 1'b1;
            end
            OP_UNPK2: begin
                next_result = {{WORD_W{1'b0}}, unpk_lo};
                next_wide   = 1'b0;
            end
            OP_UNPK4: begin
                next_result = unpk_hi;
                next_wide   = 1'b1;
            end
            OP_SHB, OP_SHH: begin
                next_result = shifted;
                next_wide   = 1'b1;
            end
            default: begin
                next_result = '0;
                next_wide   = 1'b0;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FRESH : ST_EMPTY;
            ST_FRESH: state_d = in_valid ? ST_FRESH : ST_HELD;
            ST_HELD:  state_d = in_valid ? ST_FRESH : ST_HELD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_wide   <= 1'b0;
        end else if (in_valid) begin
            out_result <= next_result;
            out_wide   <= next_wide;
        end
    end

    assign out_valid = (state_q == ST_FRESH);

endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
    parameter int unsigned PAIR_W = 64,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic              in_sign,
    input logic [PAIR_W-1:0] rd_data,
    input logic [PAIR_W-1:0] pair_in,
    input logic              out_valid,
    input logic [PAIR_W-1:0] out_result,
    input logic              out_wide
);
    localparam int unsigned WORD_W = PAIR_W / 2;
    localparam int unsigned HALF_W = 2 * BYTE_W;

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_wide)));

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_result[PAIR_W-1:WORD_W] == '0));

    p_pair_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd3) |=> (out_wide && out_result == $past(rd_data)));

    p_shift_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd6) |=>
        (out_result[PAIR_W-BYTE_W-1:0] == $past(pair_in[PAIR_W-1:BYTE_W])));

    p_shift_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |=>
        (out_result[PAIR_W-1:PAIR_W-HALF_W] == $past(rd_data[HALF_W-1:0])));

    p_unused_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd6) |=> (out_result[PAIR_W-1:PAIR_W-BYTE_W] == $past(rd_data[BYTE_W-1:0])));

    // in_sign is only observed through the result paths above
    logic unused_sign;
    assign unused_sign = in_sign;

endmodule

bind ldx_unit ldx_unit_chk #(.PAIR_W(PAIR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_sign    (in_sign),
    .rd_data    (rd_data),
    .pair_in    (pair_in),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_wide   (out_wide)
);

// File: tb/ldx_unit_test.sv
module ldx_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic        in_sign = 1'b0;
    logic [63:0] rd_data = 64'h0;
    logic [63:0] pair_in = 64'h0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wide;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ldx_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_sign    (in_sign),
        .rd_data    (rd_data),
        .pair_in    (pair_in),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_wide   (out_wide)
    );

    // Reference result {wide, value} built from the requirement text
    function automatic logic [64:0] model(input logic [2:0] op, input logic sgn,
                                          input logic [63:0] d, input logic [63:0] old);
        logic [63:0] r;
        logic        w;
        r = 64'h0;
        w = 1'b0;
        case (op)
            3'd0: r[31:0] = sgn ? 32'($signed(d[7:0]))  : {24'h0, d[7:0]};
            3'd1: r[31:0] = sgn ? 32'($signed(d[15:0])) : {16'h0, d[15:0]};
            3'd2: r[31:0] = d[31:0];
            3'd3: begin r = d; w = 1'b1; end
            3'd4: for (int k = 0; k < 2; k++)
                      r[16*k +: 16] = sgn ? 16'($signed(d[8*k +: 8])) : {8'h0, d[8*k +: 8]};
            3'd5: begin
                      for (int k = 0; k < 4; k++)
                          r[16*k +: 16] = sgn ? 16'($signed(d[8*k +: 8])) : {8'h0, d[8*k +: 8]};
                      w = 1'b1;
                  end
            3'd6: begin r = (old >> 8)  | ({56'h0, d[7:0]}  << 56); w = 1'b1; end
            default: begin r = (old >> 16) | ({48'h0, d[15:0]} << 48); w = 1'b1; end
        endcase
        return {w, r};
    endfunction

    task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic sgn,
                         input logic [63:0] d, input logic [63:0] old);
        in_valid = 1'b1;
        in_op    = op;
        in_sign  = sgn;
        rd_data  = d;
        pair_in  = old;
    endtask

    // One isolated request: drive at a falling edge, look at the next one
    task automatic one_shot(input string tag, input logic [2:0] op, input logic sgn,
                            input logic [63:0] d, input logic [63:0] old,
                            input logic [64:0] fixed_exp);
        @(negedge clk);
        drive(op, sgn, d, old);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " strobe"}, {64'h0, out_valid}, 65'h1);
        check(tag, {out_wide, out_result}, model(op, sgn, d, old));
        check({tag, " const"}, {out_wide, out_result}, fixed_exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset", {out_valid, out_wide, out_result[62:0]}, 65'h0);
        check("R1 reset msb", {64'h0, out_result[63]}, 65'h0);
    endtask

    task automatic t_byte;
        one_shot("R2 byte signed, R12 upper ignored", 3'd0, 1'b1, 64'hDEAD_BEEF_1234_5685, 64'h0,
                 {1'b0, 64'h0000_0000_FFFF_FF85});
        one_shot("R2 byte unsigned, R12", 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF85, 64'h0,
                 {1'b0, 64'h0000_0000_0000_0085});
        @(negedge clk);
        check("R10 strobe drops", {64'h0, out_valid}, 65'h0);
    endtask

    task automatic t_half;
        one_shot("R3 half signed", 3'd1, 1'b1, 64'h7777_7777_7777_8001, 64'h0,
                 {1'b0, 64'h0000_0000_FFFF_8001});
        one_shot("R3 half unsigned", 3'd1, 1'b0, 64'h0000_0000_0000_8001, 64'h0,
                 {1'b0, 64'h0000_0000_0000_8001});
    endtask

    task automatic t_word;
        one_shot("R4 word", 3'd2, 1'b1, 64'hAAAA_5555_8765_4321, 64'h0,
                 {1'b0, 64'h0000_0000_8765_4321});
    endtask

    task automatic t_pair;
        one_shot("R5 doubleword", 3'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0,
                 {1'b1, 64'h0123_4567_89AB_CDEF});
    endtask

    task automatic t_unpack2;
        one_shot("R6 unpack2 signed", 3'd4, 1'b1, 64'hFFFF_FFFF_1111_807F, 64'h0,
                 {1'b0, 64'h0000_0000_FF80_007F});
        one_shot("R6 unpack2 unsigned", 3'd4, 1'b0, 64'hFFFF_FFFF_1111_807F, 64'h0,
                 {1'b0, 64'h0000_0000_0080_007F});
    endtask

    task automatic t_unpack4;
        one_shot("R7 unpack4 signed", 3'd5, 1'b1, 64'h9999_9999_F001_807F, 64'h0,
                 {1'b1, 64'hFFF0_0001_FF80_007F});
        one_shot("R7 unpack4 unsigned", 3'd5, 1'b0, 64'h9999_9999_F001_807F, 64'h0,
                 {1'b1, 64'h00F0_0001_0080_007F});
    endtask

    // Back-to-back shift-in chain: each result is fed back as the old pair
    task automatic t_fifo_chain;
        logic [63:0] p0;
        logic [63:0] p1;
        logic [63:0] p2;
        p0 = 64'h1122_3344_5566_7788;
        p1 = 64'hAB11_2233_4455_6677;
        p2 = 64'hC0DE_AB11_2233_4455;
        @(negedge clk);
        drive(3'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFAB, p0);
        @(negedge clk);
        check("R10 chain strobe 1", {64'h0, out_valid}, 65'h1);
        check("R8 byte shift-in", {out_wide, out_result}, {1'b1, p1});
        drive(3'd7, 1'b1, 64'h5555_5555_5555_C0DE, out_result);
        @(negedge clk);
        check("R10 chain strobe 2", {64'h0, out_valid}, 65'h1);
        check("R9 half shift-in", {out_wide, out_result}, {1'b1, p2});
        drive(3'd6, 1'b0, 64'h0000_0000_0000_0042, out_result);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 chain strobe 3", {64'h0, out_valid}, 65'h1);
        check("R8 byte shift-in 2", {out_wide, out_result}, model(3'd6, 1'b0, 64'h42, p2));
        @(negedge clk);
        check("R10 strobe after chain", {64'h0, out_valid}, 65'h0);
    endtask

    // Idle inputs churn without in_valid; the result must not move
    task automatic t_hold;
        logic [64:0] kept;
        one_shot("R9 half shift-in single", 3'd7, 1'b0, 64'h0000_0000_0000_BEEF,
                 64'h0102_0304_0506_0708, {1'b1, 64'hBEEF_0102_0304_0506});
        kept = {out_wide, out_result};
        for (int k = 0; k < 4; k++) begin
            in_op   = 3'(k);
            in_sign = k[0];
            rd_data = {16{4'(k + 3)}};
            pair_in = ~rd_data;
            @(negedge clk);
            check("R11 held result", {out_wide, out_result}, kept);
            check("R11 no strobe", {64'h0, out_valid}, 65'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_byte();
        t_half();
        t_word();
        t_pair();
        t_unpack2();
        t_unpack4();
        t_fifo_chain();
        t_hold();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule